// File: doc/BRIEF.md
# USB Full-Speed Frame Timer

This block produces the frame timing for a full-speed USB host controller. Software writes a 32-bit frame control word holding an interval toggle flag, a largest-packet budget and a 14-bit frame interval in bit-times. The block has a bit-time strobe input. On each strobe it counts a 14-bit frame-remaining value down towards zero. The strobe after the count reaches zero reloads the programmed interval, starts a new frame, advances a 16-bit frame number and raises a one-cycle start-of-frame pulse.

A toggle flag is copied from the control word into the frame-remaining toggle output only when the count reaches zero. Software can compare the two flags to learn whether a newly written interval is already in force. A 15-bit packet budget counter is seeded from the control word at each frame start and then runs down to zero within the frame. An enter-operational pulse starts the counting. A host reset input returns the interval to its nominal value and stops the timer.

Control word layout: bit 31 is the interval toggle, bits 30:16 are the packet budget seed, bits 13:0 are the interval, and bits 15:14 are ignored.

Top module: `usb_frame_timer`

## Requirements
- R1: While operating, each cycle with `bit_tick` high and `frm_left` not 0 lowers `frm_left` by exactly one, visible after that clock edge.
- R2: While operating, a `bit_tick` cycle with `frm_left` equal to 0 loads `frm_left` with the 14-bit interval field (bits 13:0) of the stored control word and starts a new frame.
- R3: `frm_left_tgl` takes the stored toggle flag (control bit 31) on the `bit_tick` at which `frm_left` becomes 0, and at no other time outside reset.
- R4: A cycle with `host_rst` high sets the stored interval to 11999, clears `frm_left`, `frm_left_tgl`, `frm_num` and `pkt_budget`, and stops counting until the next `go_oper`.
- R5: At every frame start, `pkt_budget` is loaded from control bits 30:16.
- R6: At every frame start, `frm_num` rises by one modulo 65536, and `sof` is high for exactly the one cycle in which the new number first appears.
- R7: A write (`wr_en` high) changes the stored control word but leaves `frm_left` untouched; the new interval is first seen at the next reload.
- R8: A `go_oper` pulse immediately loads `frm_left` with the stored interval and `pkt_budget` with the stored budget seed. It raises no `sof` and leaves `frm_num` unchanged.
- R9: Before the first `go_oper` after reset or `host_rst`, `bit_tick` has no effect on any output.
- R10: After `rst_n` low, `frm_left`, `frm_left_tgl`, `frm_num`, `pkt_budget` and `sof` are 0, the stored interval is 11999, and the stored toggle and budget seed are 0.
- R11: Within a frame, `pkt_budget` falls by one on each `bit_tick` and holds at 0 once it gets there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rst | input | 1 | Host controller reset request |
| go_oper | input | 1 | Enter-operational pulse |
| bit_tick | input | 1 | One-cycle strobe per bit-time |
| wr_en | input | 1 | Control word write enable |
| wr_data | input | 32 | Control word |
| frm_left | output | 14 | Bit-times left in the current frame |
| frm_left_tgl | output | 1 | Toggle flag captured at count zero |
| frm_num | output | 16 | Frame number |
| sof | output | 1 | Start-of-frame pulse |
| pkt_budget | output | 15 | Largest-packet budget counter |

## Verification
Every output is registered. A tick, write, operational pulse or host reset sampled at one clock edge shows its result on all outputs right after that edge, and `sof` falls again one edge later. The bench drives inputs on the falling edge and samples on the next falling edge, half a cycle after the result is due. The pulse width of `sof` is checked one further falling edge later. For the table runs, the expected count, frame number and budget after k contiguous ticks come from closed-form arithmetic on k and the interval N + 1. They are not produced by a step-by-step model.

// File: rtl/usb_frame_timer_pkg.sv
package usb_frame_timer_pkg;
    localparam int unsigned FR_W_DEF   = 14;
    localparam int unsigned PKT_W_DEF  = 15;
    localparam int unsigned FN_W_DEF   = 16;
    localparam int unsigned WORD_W_DEF = 32;
    localparam int unsigned NOMINAL_DEF = 11999;
    // Control word field positions
    localparam int unsigned PKT_LSB_DEF = 16;
endpackage

// File: rtl/ufrt_ctrl_reg.sv
module ufrt_ctrl_reg
    import usb_frame_timer_pkg::*;
#(
    parameter int unsigned FR_W    = FR_W_DEF,
    parameter int unsigned PKT_W   = PKT_W_DEF,
    parameter int unsigned WORD_W  = WORD_W_DEF,
    parameter int unsigned PKT_LSB = PKT_LSB_DEF,
    parameter int unsigned NOMINAL = NOMINAL_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [FR_W-1:0]   ivl,
    output logic              ivl_tgl,
    output logic [PKT_W-1:0]  pkt_seed
);
    localparam int unsigned TGL_POS = WORD_W - 1;
    localparam logic [FR_W-1:0] NOM = FR_W'(NOMINAL);

    typedef struct packed {
        logic             tgl;
        logic [PKT_W-1:0] pkt;
        logic [FR_W-1:0]  ivl;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic unused_gap;
    assign unused_gap = ^wr_data[PKT_LSB-1:FR_W];

    always_comb begin
        ctrl_d = ctrl_q;
        if (host_rst) begin
            ctrl_d.ivl = NOM;
        end else if (wr_en) begin
            ctrl_d.tgl = wr_data[TGL_POS];
            ctrl_d.pkt = wr_data[PKT_LSB +: PKT_W];
            ctrl_d.ivl = wr_data[FR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.tgl <= 1'b0;
            ctrl_q.pkt <= '0;
            ctrl_q.ivl <= NOM;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ivl      = ctrl_q.ivl;
    assign ivl_tgl  = ctrl_q.tgl;
    assign pkt_seed = ctrl_q.pkt;
endmodule

// File: rtl/ufrt_frame_cnt.sv
module ufrt_frame_cnt
    import usb_frame_timer_pkg::*;
#(
    parameter int unsigned FR_W = FR_W_DEF,
    parameter int unsigned FN_W = FN_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_rst,
    input  logic            go_oper,
    input  logic            bit_tick,
    input  logic [FR_W-1:0] ivl,
    input  logic            ivl_tgl,
    output logic [FR_W-1:0] frm_left,
    output logic            frm_left_tgl,
    output logic [FN_W-1:0] frm_num,
    output logic            sof,
    output logic            oper,
    output logic            seed_load,
    output logic            budget_step
);
    localparam logic [FR_W-1:0] ONE = FR_W'(1);

    typedef struct packed {
        logic            run;
        logic [FR_W-1:0] left;
        logic            tgl;
        logic [FN_W-1:0] num;
        logic            sof;
    } fcnt_t;

    fcnt_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.sof    = 1'b0;
        seed_load   = 1'b0;
        budget_step = 1'b0;
        if (host_rst) begin
            st_d = '0;
        end else if (go_oper) begin
            st_d.run  = 1'b1;
            st_d.left = ivl;
            seed_load = 1'b1;
        end else if (st_q.run && bit_tick) begin
            if (st_q.left == '0) begin
                st_d.left = ivl;
                st_d.num  = st_q.num + 1'b1;
                st_d.sof  = 1'b1;
                seed_load = 1'b1;
                if (ivl == '0) begin
                    st_d.tgl = ivl_tgl;
                end
            end else begin
                st_d.left   = st_q.left - ONE;
                budget_step = 1'b1;
                if (st_q.left == ONE) begin
                    st_d.tgl = ivl_tgl;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frm_left     = st_q.left;
    assign frm_left_tgl = st_q.tgl;
    assign frm_num      = st_q.num;
    assign sof          = st_q.sof;
    assign oper         = st_q.run;
endmodule

// File: rtl/ufrt_pkt_budget.sv
module ufrt_pkt_budget
    import usb_frame_timer_pkg::*;
#(
    parameter int unsigned PKT_W = PKT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic             step,
    input  logic [PKT_W-1:0] seed,
    output logic [PKT_W-1:0] budget
);
    typedef struct packed {
        logic [PKT_W-1:0] cnt;
    } bud_t;

    bud_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (clr) begin
            b_d.cnt = '0;
        end else if (load) begin
            b_d.cnt = seed;
        end else if (step && (b_q.cnt != '0)) begin
            b_d.cnt = b_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign budget = b_q.cnt;
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
    import usb_frame_timer_pkg::*;
#(
    parameter int unsigned FR_W    = FR_W_DEF,
    parameter int unsigned PKT_W   = PKT_W_DEF,
    parameter int unsigned FN_W    = FN_W_DEF,
    parameter int unsigned WORD_W  = WORD_W_DEF,
    parameter int unsigned PKT_LSB = PKT_LSB_DEF,
    parameter int unsigned NOMINAL = NOMINAL_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rst,
    input  logic              go_oper,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [FR_W-1:0]   frm_left,
    output logic              frm_left_tgl,
    output logic [FN_W-1:0]   frm_num,
    output logic              sof,
    output logic [PKT_W-1:0]  pkt_budget
);
    logic [FR_W-1:0]  ivl_w;
    logic             ivl_tgl_w;
    logic [PKT_W-1:0] seed_w;
    logic             oper_w;
    logic             seed_load_w;
    logic             step_w;

    ufrt_ctrl_reg #(
        .FR_W(FR_W), .PKT_W(PKT_W), .WORD_W(WORD_W),
        .PKT_LSB(PKT_LSB), .NOMINAL(NOMINAL)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .host_rst(host_rst),
        .wr_en(wr_en), .wr_data(wr_data),
        .ivl(ivl_w), .ivl_tgl(ivl_tgl_w), .pkt_seed(seed_w)
    );

    ufrt_frame_cnt #(.FR_W(FR_W), .FN_W(FN_W)) u_fcnt (
        .clk(clk), .rst_n(rst_n), .host_rst(host_rst),
        .go_oper(go_oper), .bit_tick(bit_tick),
        .ivl(ivl_w), .ivl_tgl(ivl_tgl_w),
        .frm_left(frm_left), .frm_left_tgl(frm_left_tgl),
        .frm_num(frm_num), .sof(sof), .oper(oper_w),
        .seed_load(seed_load_w), .budget_step(step_w)
    );

    ufrt_pkt_budget #(.PKT_W(PKT_W)) u_bud (
        .clk(clk), .rst_n(rst_n), .clr(host_rst),
        .load(seed_load_w), .step(step_w),
        .seed(seed_w), .budget(pkt_budget)
    );
endmodule

// File: rtl/usb_frame_timer_chk.sv
module usb_frame_timer_chk #(
    parameter int unsigned FR_W    = 14,
    parameter int unsigned PKT_W   = 15,
    parameter int unsigned FN_W    = 16,
    parameter int unsigned NOMINAL = 11999
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_rst,
    input logic             go_oper,
    input logic             bit_tick,
    input logic             oper,
    input logic [FR_W-1:0]  ivl,
    input logic             ivl_tgl,
    input logic [FR_W-1:0]  frm_left,
    input logic             frm_left_tgl,
    input logic [FN_W-1:0]  frm_num,
    input logic             sof,
    input logic [PKT_W-1:0] pkt_budget
);
    logic plain_tick;
    assign plain_tick = oper && bit_tick && !host_rst && !go_oper;

    p_dec_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_tick && frm_left != '0) |=> (frm_left == $past(frm_left) - 1'b1));

    p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_tick && frm_left == '0) |=> (sof && frm_left == $past(ivl)));

    p_tgl_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_tick && frm_left == FR_W'(1)) |=> (frm_left_tgl == $past(ivl_tgl)));

    p_host_rst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        host_rst |=> (!oper && ivl == FR_W'(NOMINAL) && frm_num == '0 && pkt_budget == '0));

    p_sof_num_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> (frm_num == $past(frm_num) + 1'b1));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!oper && !go_oper && !host_rst) |=> ($stable(frm_left) && $stable(frm_num) && !sof));

    p_budget_floor_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_tick && frm_left != '0 && pkt_budget == '0) |=> (pkt_budget == '0));
endmodule

bind usb_frame_timer usb_frame_timer_chk #(
    .FR_W(FR_W), .PKT_W(PKT_W), .FN_W(FN_W), .NOMINAL(NOMINAL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_rst(host_rst), .go_oper(go_oper),
    .bit_tick(bit_tick), .oper(oper_w), .ivl(ivl_w), .ivl_tgl(ivl_tgl_w),
    .frm_left(frm_left), .frm_left_tgl(frm_left_tgl), .frm_num(frm_num),
    .sof(sof), .pkt_budget(pkt_budget)
);

// File: tb/usb_frame_timer_bench.sv
module usb_frame_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_rst = 1'b0;
    logic        go_oper = 1'b0;
    logic        bit_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [13:0] frm_left;
    logic        frm_left_tgl;
    logic [15:0] frm_num;
    logic        sof;
    logic [14:0] pkt_budget;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    usb_frame_timer u_usb_frame_timer (
        .clk(clk), .rst_n(rst_n), .host_rst(host_rst), .go_oper(go_oper),
        .bit_tick(bit_tick), .wr_en(wr_en), .wr_data(wr_data),
        .frm_left(frm_left), .frm_left_tgl(frm_left_tgl), .frm_num(frm_num),
        .sof(sof), .pkt_budget(pkt_budget)
    );

    // {interval, budget seed, tick count}
    localparam logic [44:0] VEC [0:3] = '{
        {14'd5,  15'd3,  16'd20},
        {14'd0,  15'd2,  16'd4},
        {14'd10, 15'd20, 16'd25},
        {14'd1,  15'd0,  16'd7}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic tg, input int pkt, input int ivl);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = {tg, 15'(pkt), 2'b00, 14'(ivl)};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic go();
        @(negedge clk);
        go_oper = 1'b1;
        @(negedge clk);
        go_oper = 1'b0;
    endtask

    task automatic hrst();
        @(negedge clk);
        host_rst = 1'b1;
        @(negedge clk);
        host_rst = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        bit_tick = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 frm_left", int'(frm_left), 0);
        chk("R10 tgl", int'(frm_left_tgl), 0);
        chk("R10 frm_num", int'(frm_num), 0);
        chk("R10 budget", int'(pkt_budget), 0);
        chk("R10 sof", int'(sof), 0);

        // R9 ticks ignored before operating
        ticks(5);
        chk("R9 frm_left idle", int'(frm_left), 0);
        chk("R9 frm_num idle", int'(frm_num), 0);
        chk("R9 budget idle", int'(pkt_budget), 0);

        // R10 stored interval nominal after reset: seen through go_oper
        go();
        chk("R10 nominal interval", int'(frm_left), 11999);

        // Table walk
        for (int i = 0; i < 4; i++) begin
            int n, p, k, m, fr;
            n = int'(VEC[i][44:31]);
            p = int'(VEC[i][30:16]);
            k = int'(VEC[i][15:0]);
            base = int'(frm_num);
            wr(1'b0, p, n);
            go();
            chk("R8 load frm_left", int'(frm_left), n);
            chk("R8 load budget", int'(pkt_budget), p);
            chk("R8 frm_num kept", int'(frm_num), base);
            chk("R8 no sof", int'(sof), 0);
            ticks(k);
            fr = k / (n + 1);
            m  = k % (n + 1);
            chk("R1 R2 frm_left", int'(frm_left), n - m);
            chk("R6 frm_num", int'(frm_num), (base + fr) % 65536);
            chk("R6 sof", int'(sof), (m == 0) ? 1 : 0);
            chk("R5 R11 budget", int'(pkt_budget), (m >= p) ? 0 : p - m);
        end

        // R7 write mid-frame, R3 toggle copy at zero
        wr(1'b0, 4, 5);
        go();
        ticks(2);
        chk("R1 mid", int'(frm_left), 3);
        wr(1'b1, 9, 8);
        chk("R7 frm_left untouched", int'(frm_left), 3);
        chk("R3 tgl before zero", int'(frm_left_tgl), 0);
        ticks(2);
        chk("R7 old frame continues", int'(frm_left), 1);
        chk("R3 tgl still old", int'(frm_left_tgl), 0);
        chk("R11 budget floor", int'(pkt_budget), 0);
        ticks(1);
        chk("R3 tgl copied at zero", int'(frm_left_tgl), 1);
        chk("R3 frm_left zero", int'(frm_left), 0);
        base = int'(frm_num);
        ticks(1);
        chk("R7 new interval at reload", int'(frm_left), 8);
        chk("R5 new seed", int'(pkt_budget), 9);
        chk("R6 sof high", int'(sof), 1);
        chk("R6 frm_num step", int'(frm_num), (base + 1) % 65536);
        @(negedge clk);
        chk("R6 sof one cycle", int'(sof), 0);

        // R4 host reset
        hrst();
        chk("R4 frm_left cleared", int'(frm_left), 0);
        chk("R4 tgl cleared", int'(frm_left_tgl), 0);
        chk("R4 frm_num cleared", int'(frm_num), 0);
        chk("R4 budget cleared", int'(pkt_budget), 0);
        ticks(3);
        chk("R4 R9 halted", int'(frm_left), 0);
        go();
        chk("R4 nominal interval", int'(frm_left), 11999);
        chk("R4 seed kept", int'(pkt_budget), 9);

        // R6 frame number wrap
        wr(1'b0, 0, 0);
        go();
        base = int'(frm_num);
        ticks(65536);
        chk("R6 wrap frm_num", int'(frm_num), base);
        chk("R6 wrap sof", int'(sof), 1);
        ticks(1);
        chk("R6 after wrap", int'(frm_num), (base + 1) % 65536);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule